// File: doc/BRIEF.md
# SDRAM Controller Configuration Register File

This block is the software-visible control plane of an SDRAM controller. It sits on a small device-control bus and exposes only two bus locations. One is an index port and the other is a data port. The host first writes the number of an internal register into the index port. It then reads or writes that register through the data port.

Behind the pair sit the following registers:

- two error-status words that the memory controller sets and software clears bit by bit;
- an error-address word;
- the global configuration and a read-only status word;
- refresh, power-management and ECC-configuration words;
- an ECC error word;
- one configuration word per memory bank.

Each write is filtered through the writable-bit mask of its register. Turning the global enable bit on or off updates the status flags and the per-bank enable outputs together. An interrupt line stays high while the ECC error word is non-zero. The DRAM command sequencer and the data path lie outside this block.

Top module: `sdram_cfg_regs`

## Requirements
- R1: A bus write to address 0x10 stores all 32 bits as the index; a read of 0x10 returns the last index written (0 after reset). Read data appears on `bus_rdata_o` after the clock edge that samples `bus_rd_i` and holds until the next read.
- R2: After reset the following values hold:
  - configuration (index 0x20) reads 0x00800000;
  - refresh (0x30) reads 0x05F00000;
  - power management (0x34) reads 0x07C00000;
  - every other stored register reads 0;
  - `mem_en_o`, `bank_en_o` and `ecc_irq_o` are low.
- R3: The error-status words at indices 0x00 and 0x08 behave as follows:
  - a data-port write clears the bits that are 1 in the written value and keeps the others;
  - a 1 on `err0_set_i` / `err1_set_i` sets the matching bit, and a set wins over a clear in the same cycle.
- R4: A configuration write keeps only bits 31:21 (mask 0xFFE00000). The error address (0x10) keeps all 32 bits.
- R5: Configuration bit 31 is the global enable and drives `mem_en_o`.
  - When a write takes bit 31 from 0 to 1, status (0x24) bit 31 is cleared.
  - When a write takes it from 1 to 0, status bit 31 is set.
- R6: When a configuration write takes bit 30 from 0 to 1, status bit 30 is set. When it takes bit 30 from 1 to 0, status bit 30 is cleared.
- R7: Writes to the status index 0x24 have no effect.
- R8: Write masks apply as follows:
  - refresh keeps 0x3FF80000;
  - ECC configuration (0x94) keeps 0x00F00000;
  - ECC error (0x98) keeps 0xFFF0F000;
  - power management stores bits 31:27 of the written value ORed with 0x07C00000.
- R9: The bank configuration words sit at indices 0x40, 0x44, 0x48 and 0x4C. Each keeps bits under the mask 0xFFDEE001. A bank that is not populated (its bit in BANK_POP is 0) ignores writes and reads 0.
- R10: `bank_en_o[i]` is high exactly when `mem_en_o` is high and bit 0 of bank word i is 1.
- R11: `ecc_irq_o` rises when a write makes the ECC error word non-zero from zero. It falls when a write makes the word zero. It is high exactly while the word is non-zero.
- R12: Reads of the data port return the following:
  - all ones for the timing index 0x80 and for any index not listed above;
  - 0 for any bus address other than 0x10 and 0x11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | ADDR_W | Bus address of the access |
| bus_wr_i | input | 1 | Write strobe, one cycle per access |
| bus_rd_i | input | 1 | Read strobe, one cycle per access |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| err0_set_i | input | 32 | Bits to set in error-status word 0 |
| err1_set_i | input | 32 | Bits to set in error-status word 1 |
| mem_en_o | output | 1 | Global memory enable |
| bank_en_o | output | NUM_BANKS | Per-bank mapping enable |
| ecc_irq_o | output | 1 | ECC error interrupt |

## Verification
A single set bit is walked across all 32 positions of every masked register. The bench then compares the readback with the mask, or with the OR constant for power management. This separates a wrong mask from a missing OR or a shifted field.

The bench sweeps all 256 low index values and flags a non-ones read at any unlisted index, which exposes aliasing in the index decode.

The configuration sequence drives each enable and standby edge separately. Pattern writes to the error words show the difference between write-one-to-clear, plain write and set-over-clear priority. Enable changes with mixed bank bit-0 values tell bank gating apart from the global enable.

// File: rtl/sdram_cfg_pkg.sv
package sdram_cfg_pkg;
  localparam int DW = 32;

  localparam logic [DW-1:0] IX_ERR0  = 32'h00;
  localparam logic [DW-1:0] IX_ERR1  = 32'h08;
  localparam logic [DW-1:0] IX_EADDR = 32'h10;
  localparam logic [DW-1:0] IX_CFG   = 32'h20;
  localparam logic [DW-1:0] IX_STAT  = 32'h24;
  localparam logic [DW-1:0] IX_RFSH  = 32'h30;
  localparam logic [DW-1:0] IX_PWR   = 32'h34;
  localparam logic [DW-1:0] IX_BANK0 = 32'h40;
  localparam int            BANK_STRIDE = 4;
  localparam logic [DW-1:0] IX_ECFG  = 32'h94;
  localparam logic [DW-1:0] IX_EERR  = 32'h98;

  localparam logic [DW-1:0] CFG_MASK  = 32'hFFE0_0000;
  localparam logic [DW-1:0] RFSH_MASK = 32'h3FF8_0000;
  localparam logic [DW-1:0] PWR_MASK  = 32'hF800_0000;
  localparam logic [DW-1:0] PWR_FIXED = 32'h07C0_0000;
  localparam logic [DW-1:0] ECFG_MASK = 32'h00F0_0000;
  localparam logic [DW-1:0] EERR_MASK = 32'hFFF0_F000;
  localparam logic [DW-1:0] BANK_MASK = 32'hFFDE_E001;

  localparam logic [DW-1:0] CFG_RST  = 32'h0080_0000;
  localparam logic [DW-1:0] RFSH_RST = 32'h05F0_0000;

  localparam int EN_BIT  = 31;
  localparam int SBY_BIT = 30;

  typedef struct packed {
    logic err0;
    logic err1;
    logic eaddr;
    logic cfg;
    logic rfsh;
    logic pwr;
    logic ecfg;
    logic eerr;
  } sel_t;
endpackage

// File: rtl/sdram_cfg_index.sv
module sdram_cfg_index
  import sdram_cfg_pkg::*;
#(
  parameter int NUM_BANKS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic [DW-1:0]        wdata_i,
  output logic [DW-1:0]        idx_o,
  output sel_t                 sel_o,
  output logic                 stat_sel_o,
  output logic [NUM_BANKS-1:0] bank_sel_o
);
  logic [DW-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idx_q <= '0;
    else if (wr_i) idx_q <= wdata_i;
  end

  assign idx_o = idx_q;

  always_comb begin
    sel_o.err0  = (idx_q == IX_ERR0);
    sel_o.err1  = (idx_q == IX_ERR1);
    sel_o.eaddr = (idx_q == IX_EADDR);
    sel_o.cfg   = (idx_q == IX_CFG);
    sel_o.rfsh  = (idx_q == IX_RFSH);
    sel_o.pwr   = (idx_q == IX_PWR);
    sel_o.ecfg  = (idx_q == IX_ECFG);
    sel_o.eerr  = (idx_q == IX_EERR);
  end

  assign stat_sel_o = (idx_q == IX_STAT);

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bsel
    localparam logic [DW-1:0] BIX = IX_BANK0 + DW'(g * BANK_STRIDE);
    assign bank_sel_o[g] = (idx_q == BIX);
  end

  p_sel_onehot_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sel_o, stat_sel_o, bank_sel_o}));
endmodule

// File: rtl/sdram_cfg_ctl.sv
module sdram_cfg_ctl
  import sdram_cfg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  sel_t          wr_sel_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] err0_set_i,
  input  logic [DW-1:0] err1_set_i,
  output logic [DW-1:0] err0_o,
  output logic [DW-1:0] err1_o,
  output logic [DW-1:0] eaddr_o,
  output logic [DW-1:0] cfg_o,
  output logic [DW-1:0] stat_o,
  output logic [DW-1:0] rfsh_o,
  output logic [DW-1:0] pwr_o,
  output logic [DW-1:0] ecfg_o,
  output logic          mem_en_o
);
  logic [DW-1:0] err0_q, err1_q, eaddr_q, cfg_q, stat_q, rfsh_q, pwr_q, ecfg_q;
  logic [DW-1:0] cfg_nv, clr0, clr1;

  assign cfg_nv = wdata_i & CFG_MASK;
  assign clr0   = wr_sel_i.err0 ? wdata_i : '0;
  assign clr1   = wr_sel_i.err1 ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err0_q  <= '0;
      err1_q  <= '0;
      eaddr_q <= '0;
      cfg_q   <= CFG_RST;
      stat_q  <= '0;
      rfsh_q  <= RFSH_RST;
      pwr_q   <= PWR_FIXED;
      ecfg_q  <= '0;
    end else begin
      // set from the controller wins over software clear
      err0_q <= (err0_q & ~clr0) | err0_set_i;
      err1_q <= (err1_q & ~clr1) | err1_set_i;
      if (wr_sel_i.eaddr) eaddr_q <= wdata_i;
      if (wr_sel_i.rfsh)  rfsh_q  <= wdata_i & RFSH_MASK;
      if (wr_sel_i.pwr)   pwr_q   <= (wdata_i & PWR_MASK) | PWR_FIXED;
      if (wr_sel_i.ecfg)  ecfg_q  <= wdata_i & ECFG_MASK;
      if (wr_sel_i.cfg) begin
        if (!cfg_q[EN_BIT] && cfg_nv[EN_BIT])      stat_q[EN_BIT] <= 1'b0;
        else if (cfg_q[EN_BIT] && !cfg_nv[EN_BIT]) stat_q[EN_BIT] <= 1'b1;
        if (!cfg_q[SBY_BIT] && cfg_nv[SBY_BIT])      stat_q[SBY_BIT] <= 1'b1;
        else if (cfg_q[SBY_BIT] && !cfg_nv[SBY_BIT]) stat_q[SBY_BIT] <= 1'b0;
        cfg_q <= cfg_nv;
      end
    end
  end

  assign err0_o   = err0_q;
  assign err1_o   = err1_q;
  assign eaddr_o  = eaddr_q;
  assign cfg_o    = cfg_q;
  assign stat_o   = stat_q;
  assign rfsh_o   = rfsh_q;
  assign pwr_o    = pwr_q;
  assign ecfg_o   = ecfg_q;
  assign mem_en_o = cfg_q[EN_BIT];

  p_en_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_en_o) |-> !stat_q[EN_BIT]);
  p_en_fall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_en_o) |-> stat_q[EN_BIT]);
  p_sby_track_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_q[SBY_BIT]) |-> stat_q[SBY_BIT]);
  p_stat_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_sel_i.cfg |=> $stable(stat_q));
  p_w1c_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_sel_i.err0 && err0_set_i == '0) |=> ((err0_q & $past(wdata_i)) == '0));
endmodule

// File: rtl/sdram_cfg_bank.sv
module sdram_cfg_bank
  import sdram_cfg_pkg::*;
#(
  parameter bit POPULATED = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          mem_en_i,
  output logic [DW-1:0] bcr_o,
  output logic          en_o
);
  logic [DW-1:0] bcr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bcr_q <= '0;
    else if (wr_i && POPULATED) bcr_q <= wdata_i & BANK_MASK;
  end

  assign bcr_o = bcr_q;
  assign en_o  = bcr_q[0] & mem_en_i;

  p_bank_gate_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_o |-> mem_en_i);
  p_bank_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(bcr_q));
endmodule

// File: rtl/sdram_cfg_ecc.sv
module sdram_cfg_ecc
  import sdram_cfg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] eerr_o,
  output logic          irq_o
);
  logic [DW-1:0] eerr_q, nv;
  logic          irq_q;

  assign nv = wdata_i & EERR_MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eerr_q <= '0;
      irq_q  <= 1'b0;
    end else if (wr_i) begin
      if (eerr_q == '0 && nv != '0)      irq_q <= 1'b1;
      else if (eerr_q != '0 && nv == '0) irq_q <= 1'b0;
      eerr_q <= nv;
    end
  end

  assign eerr_o = eerr_q;
  assign irq_o  = irq_q;

  p_irq_rise_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && eerr_q == '0 && (wdata_i & EERR_MASK) != '0) |=> irq_o);
  p_irq_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eerr_q == '0) |-> !irq_o);
endmodule

// File: rtl/sdram_cfg_regs.sv
module sdram_cfg_regs
  import sdram_cfg_pkg::*;
#(
  parameter int                   ADDR_W    = 10,
  parameter logic [ADDR_W-1:0]    IDX_ADDR  = 10'h010,
  parameter logic [ADDR_W-1:0]    DATA_ADDR = 10'h011,
  parameter int                   NUM_BANKS = 4,
  parameter logic [NUM_BANKS-1:0] BANK_POP  = '1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic                 bus_wr_i,
  input  logic                 bus_rd_i,
  input  logic [DW-1:0]        bus_wdata_i,
  output logic [DW-1:0]        bus_rdata_o,
  input  logic [DW-1:0]        err0_set_i,
  input  logic [DW-1:0]        err1_set_i,
  output logic                 mem_en_o,
  output logic [NUM_BANKS-1:0] bank_en_o,
  output logic                 ecc_irq_o
);
  logic                 wr_idx, wr_dat;
  logic [DW-1:0]        idx;
  sel_t                 sel, wr_sel;
  logic                 stat_sel;
  logic [NUM_BANKS-1:0] bank_sel;
  logic [DW-1:0]        err0, err1, eaddr, cfg, stat, rfsh, pwr, ecfg, eerr;
  logic [DW-1:0]        bcr [NUM_BANKS];
  logic [DW-1:0]        dat_val, rd_val, rdata_q;

  assign wr_idx = bus_wr_i && (bus_addr_i == IDX_ADDR);
  assign wr_dat = bus_wr_i && (bus_addr_i == DATA_ADDR);
  assign wr_sel = wr_dat ? sel : '0;

  sdram_cfg_index #(.NUM_BANKS(NUM_BANKS)) u_index (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_idx),
    .wdata_i    (bus_wdata_i),
    .idx_o      (idx),
    .sel_o      (sel),
    .stat_sel_o (stat_sel),
    .bank_sel_o (bank_sel)
  );

  sdram_cfg_ctl u_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_sel_i   (wr_sel),
    .wdata_i    (bus_wdata_i),
    .err0_set_i (err0_set_i),
    .err1_set_i (err1_set_i),
    .err0_o     (err0),
    .err1_o     (err1),
    .eaddr_o    (eaddr),
    .cfg_o      (cfg),
    .stat_o     (stat),
    .rfsh_o     (rfsh),
    .pwr_o      (pwr),
    .ecfg_o     (ecfg),
    .mem_en_o   (mem_en_o)
  );

  sdram_cfg_ecc u_ecc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_sel.eerr),
    .wdata_i (bus_wdata_i),
    .eerr_o  (eerr),
    .irq_o   (ecc_irq_o)
  );

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    sdram_cfg_bank #(.POPULATED(BANK_POP[g])) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_i     (wr_dat && bank_sel[g]),
      .wdata_i  (bus_wdata_i),
      .mem_en_i (mem_en_o),
      .bcr_o    (bcr[g]),
      .en_o     (bank_en_o[g])
    );
  end

  // timing index and unlisted indices fall through to all ones
  always_comb begin
    dat_val = '1;
    if (sel.err0)  dat_val = err0;
    if (sel.err1)  dat_val = err1;
    if (sel.eaddr) dat_val = eaddr;
    if (sel.cfg)   dat_val = cfg;
    if (stat_sel)  dat_val = stat;
    if (sel.rfsh)  dat_val = rfsh;
    if (sel.pwr)   dat_val = pwr;
    if (sel.ecfg)  dat_val = ecfg;
    if (sel.eerr)  dat_val = eerr;
    for (int i = 0; i < NUM_BANKS; i++)
      if (bank_sel[i]) dat_val = bcr[i];
  end

  always_comb begin
    if (bus_addr_i == IDX_ADDR)       rd_val = idx;
    else if (bus_addr_i == DATA_ADDR) rd_val = dat_val;
    else                              rd_val = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (bus_rd_i) rdata_q <= rd_val;
  end

  assign bus_rdata_o = rdata_q;

  p_rdata_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_rd_i |=> $stable(bus_rdata_o));
  p_irq_low_when_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_sel.eerr && (bus_wdata_i & EERR_MASK) == '0) |=> !ecc_irq_o);
endmodule

// File: tb/sdram_cfg_regs_bench.sv
module sdram_cfg_regs_bench;
  localparam logic [3:0] POP = 4'b0111;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0, rdata;
  logic [31:0] set0 = '0, set1 = '0;
  logic        mem_en, irq;
  logic [3:0]  bank_en;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  sdram_cfg_regs #(.NUM_BANKS(4), .BANK_POP(POP)) u_sdram_cfg_regs (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wr_i(wr),
    .bus_rd_i(rd), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .err0_set_i(set0), .err1_set_i(set1), .mem_en_o(mem_en),
    .bank_en_o(bank_en), .ecc_irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic wreg(input logic [31:0] ix, input logic [31:0] d);
    bus_wr(10'h010, ix); bus_wr(10'h011, d);
  endtask

  task automatic rreg(input logic [31:0] ix, output logic [31:0] d);
    bus_wr(10'h010, ix); bus_rd(10'h011, d);
  endtask

  task automatic sweep(input string tag, input logic [31:0] ix,
                       input logic [31:0] mask, input logic [31:0] orv);
    logic [31:0] v;
    for (int b = 0; b < 32; b++) begin
      wreg(ix, 32'h1 << b); rreg(ix, v);
      chk(tag, v, ((32'h1 << b) & mask) | orv);
    end
    wreg(ix, 32'hFFFF_FFFF); rreg(ix, v); chk(tag, v, mask | orv);
    wreg(ix, 32'h0); rreg(ix, v); chk(tag, v, orv);
  endtask

  function automatic bit listed(input int k);
    return k == 8'h00 || k == 8'h08 || k == 8'h10 || k == 8'h20 || k == 8'h24 ||
           k == 8'h30 || k == 8'h34 || k == 8'h40 || k == 8'h44 || k == 8'h48 ||
           k == 8'h4C || k == 8'h94 || k == 8'h98;
  endfunction

  initial begin
    #(200000 * 8);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2 reset state
    chk("R2 mem_en", {31'b0, mem_en}, 32'h0);
    chk("R2 bank_en", {28'b0, bank_en}, 32'h0);
    chk("R2 irq", {31'b0, irq}, 32'h0);
    bus_rd(10'h010, v); chk("R1 index reset", v, 32'h0);
    rreg(32'h20, v); chk("R2 cfg", v, 32'h0080_0000);
    rreg(32'h30, v); chk("R2 rfsh", v, 32'h05F0_0000);
    rreg(32'h34, v); chk("R2 pwr", v, 32'h07C0_0000);
    rreg(32'h24, v); chk("R2 stat", v, 32'h0);
    rreg(32'h00, v); chk("R2 err0", v, 32'h0);
    rreg(32'h98, v); chk("R2 eerr", v, 32'h0);
    rreg(32'h40, v); chk("R2 bank0", v, 32'h0);

    // R1 index readback
    for (int b = 0; b < 32; b++) begin
      bus_wr(10'h010, 32'h1 << b); bus_rd(10'h010, v);
      chk("R1 index", v, 32'h1 << b);
    end
    bus_wr(10'h010, 32'h20); bus_rd(10'h011, v);
    @(negedge clk); @(negedge clk);
    chk("R1 rdata hold", rdata, 32'h0080_0000);

    // R12 index sweep
    for (int k = 0; k < 256; k++) begin
      if (!listed(k)) begin
        rreg(32'(k), v); chk("R12 unlisted", v, 32'hFFFF_FFFF);
      end
    end
    wreg(32'h80, 32'h1234_5678); rreg(32'h80, v); chk("R12 timing", v, 32'hFFFF_FFFF);
    rreg(32'h140, v); chk("R12 wide index", v, 32'hFFFF_FFFF);
    bus_rd(10'h012, v); chk("R12 other addr", v, 32'h0);
    bus_rd(10'h000, v); chk("R12 other addr", v, 32'h0);

    // R4 R8 R9 masks
    sweep("R4 eaddr", 32'h10, 32'hFFFF_FFFF, 32'h0);
    sweep("R8 rfsh", 32'h30, 32'h3FF8_0000, 32'h0);
    sweep("R8 pwr", 32'h34, 32'hF800_0000, 32'h07C0_0000);
    sweep("R8 ecfg", 32'h94, 32'h00F0_0000, 32'h0);
    sweep("R9 bank0", 32'h40, 32'hFFDE_E001, 32'h0);
    sweep("R9 bank1", 32'h44, 32'hFFDE_E001, 32'h0);
    sweep("R9 bank2", 32'h48, 32'hFFDE_E001, 32'h0);
    sweep("R9 bank3 unpopulated", 32'h4C, 32'h0, 32'h0);
    sweep("R4 cfg", 32'h20, 32'hFFE0_0000, 32'h0);

    // R5 R6 sequence; cfg sweep left stat = 0x80000000
    rreg(32'h24, v); chk("R5 stat after sweep", v, 32'h8000_0000);
    wreg(32'h20, 32'h8000_0000);
    rreg(32'h24, v); chk("R5 enable clears", v, 32'h0);
    chk("R5 mem_en on", {31'b0, mem_en}, 32'h1);
    wreg(32'h20, 32'hC000_0000);
    rreg(32'h24, v); chk("R6 standby sets", v, 32'h4000_0000);
    wreg(32'h20, 32'h4000_0000);
    rreg(32'h24, v); chk("R5 disable sets", v, 32'hC000_0000);
    chk("R5 mem_en off", {31'b0, mem_en}, 32'h0);
    wreg(32'h20, 32'h0);
    rreg(32'h24, v); chk("R6 standby clears", v, 32'h8000_0000);

    // R7 status ignores writes
    wreg(32'h24, 32'h0); rreg(32'h24, v); chk("R7 stat write0", v, 32'h8000_0000);
    wreg(32'h24, 32'hFFFF_FFFF); rreg(32'h24, v); chk("R7 stat write1", v, 32'h8000_0000);

    // R11 ECC error and interrupt
    for (int b = 0; b < 32; b++) begin
      wreg(32'h98, 32'h1 << b); rreg(32'h98, v);
      chk("R8 eerr", v, (32'h1 << b) & 32'hFFF0_F000);
      chk("R11 irq", {31'b0, irq}, {31'b0, ((32'h1 << b) & 32'hFFF0_F000) != 0});
    end
    wreg(32'h98, 32'h0000_1000); wreg(32'h98, 32'h8000_0000);
    chk("R11 nonzero to nonzero", {31'b0, irq}, 32'h1);
    wreg(32'h98, 32'h000F_0FFF);
    chk("R11 masked to zero", {31'b0, irq}, 32'h0);

    // R3 write-one-to-clear
    @(negedge clk); set0 = 32'hA5A5_A5A5; set1 = 32'h0F0F_0000;
    @(negedge clk); set0 = '0; set1 = '0;
    rreg(32'h00, v); chk("R3 err0 set", v, 32'hA5A5_A5A5);
    wreg(32'h00, 32'h0000_FFFF); rreg(32'h00, v); chk("R3 err0 clear", v, 32'hA5A5_0000);
    rreg(32'h08, v); chk("R3 err1 set", v, 32'h0F0F_0000);
    wreg(32'h08, 32'h0100_0000); rreg(32'h08, v); chk("R3 err1 clear", v, 32'h0E0F_0000);
    bus_wr(10'h010, 32'h00);
    @(negedge clk); addr = 10'h011; wdata = 32'hFFFF_FFFF; wr = 1'b1; set0 = 32'h0000_0001;
    @(negedge clk); wr = 1'b0; set0 = '0;
    rreg(32'h00, v); chk("R3 set wins", v, 32'h0000_0001);

    // R10 bank gating
    wreg(32'h40, 32'h0000_0001);
    wreg(32'h44, 32'hFFFF_FFFF);
    wreg(32'h48, 32'h0000_0000);
    wreg(32'h4C, 32'hFFFF_FFFF);
    chk("R10 disabled", {28'b0, bank_en}, 32'h0);
    wreg(32'h20, 32'h8000_0000);
    chk("R10 enabled", {28'b0, bank_en}, 32'h3);
    wreg(32'h48, 32'h0000_0001);
    chk("R10 late bank", {28'b0, bank_en}, 32'h7);
    wreg(32'h40, 32'h0);
    chk("R10 bank off", {28'b0, bank_en}, 32'h6);
    wreg(32'h20, 32'h0);
    chk("R10 global off", {28'b0, bank_en}, 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule